// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical sync pulses, a data-enable flag and the current pixel and line coordinates for a raster display. Software sets up a mode by writing a small register file: line and frame lengths, the last visible pixel and line, where each sync pulse begins and how long it lasts, the sync polarities, a visible-window rectangle and a control word. Lengths, visible ends and sync starts are all written as the wanted count or position minus one. Sync widths are written as plain counts.

The control word holds four things. The first is a run bit that starts the counters or holds them cleared. The second is a per-axis polarity bit. The third is a plane bit that gates the visible output. The fourth is a three-bit pixel-clock choice that is passed straight out to the clock logic. Every write lands in the register file at once. The plane bit is different: it reaches the output path only when the next vertical sync pulse begins. Until then, a readback returns the requested value and the applied state remains visible on its own pin.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held and until the first write, `x`, `y`, `de`, `vis`, `plane_on`, `hsync`, `vsync`, `clk_sel` and `rd_data` are all zero.
- R2: A write to a register address is returned on `rd_data` from the next cycle on. The address map is: 0 line setup (visible-end field in bits 11:0, total field in bits 27:16); 1 line sync (start field in 11:0, width in 23:16); 2 frame setup; 3 frame sync (both laid out like 0 and 1); 4 control; 5 window top-left (left in 11:0, top in 27:16); 6 window bottom-right (right in 11:0, bottom in 27:16). Unimplemented bits and address 7 read as zero.
- R3: While running, `x` steps by one every cycle from 0 up to the line total field and then returns to 0, so a line lasts field+1 cycles.
- R4: `y` advances by one only in the cycle where `x` wraps to 0, and it returns to 0 after the line equal to the frame total field.
- R5: `de` is high only when `x` is at or below the line visible-end field and `y` is at or below the frame visible-end field.
- R6: Before polarity is applied, `hsync` is active while `x` lies from the line sync start field through start+width-1. With a width of 0 it is never active.
- R7: Before polarity is applied, `vsync` is active while `y` lies from the frame sync start field through start+height-1.
- R8: Control bit 2 inverts `hsync` and control bit 3 inverts `vsync`.
- R9: With control bit 0 (run) clear, `x` and `y` are held at 0, `de` is low, and each sync pin rests at its inactive level, which equals its polarity bit.
- R10: A change of control bit 1 (plane) appears on `plane_on` only in the cycle after the one in which the raw vertical sync pulse begins. `vis` equals `de` AND `plane_on`.
- R11: `clk_sel` follows control bits 6:4 from the cycle after the write.
- R12: `de` is further limited to the window rectangle: left ≤ `x` ≤ right and top ≤ `y` ≤ bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Inside visible area and window |
| vis | output | 1 | `de` gated by applied plane enable |
| x | output | 12 | Current pixel counter |
| y | output | 12 | Current line counter |
| clk_sel | output | 3 | Pixel-clock choice from control |
| plane_on | output | 1 | Applied plane enable |

## Verification
A counter that misses its wrap point or skips a value shows up within one line as a wrong `x` sequence. From there it spreads into shifted `de` and `hsync` edges, which the cycle-accurate model catches on the same cycle. A wrong vertical count appears on `y` and `vsync` no later than the next horizontal wrap. A plane enable that is applied too early or too late gives a `plane_on` step at a cycle other than the one just after the vertical sync rises. That mismatch appears within one frame. The bench also checks that the value read back and the value applied stay separate while the change is pending.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int NREG     = 8;
  localparam int HI_LSB   = 16;

  localparam int A_HTOT   = 0;
  localparam int A_HSYNC  = 1;
  localparam int A_VTOT   = 2;
  localparam int A_VSYNC  = 3;
  localparam int A_CTRL   = 4;
  localparam int A_WIN_TL = 5;
  localparam int A_WIN_BR = 6;

  localparam int C_RUN    = 0;
  localparam int C_PLANE  = 1;
  localparam int C_HPOL   = 2;
  localparam int C_VPOL   = 3;
  localparam int C_CLK_LO = 4;
  localparam int CLK_W    = 3;
  localparam int CTRL_W   = C_CLK_LO + CLK_W;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     htot,
  output logic [CW-1:0]     hde,
  output logic [CW-1:0]     hss,
  output logic [SW-1:0]     hsw,
  output logic [CW-1:0]     vtot,
  output logic [CW-1:0]     vde,
  output logic [CW-1:0]     vss,
  output logic [SW-1:0]     vsw,
  output logic [CW-1:0]     win_l,
  output logic [CW-1:0]     win_t,
  output logic [CW-1:0]     win_r,
  output logic [CW-1:0]     win_b,
  output logic [CTRL_W-1:0] ctrl
);
  function automatic logic [DATA_W-1:0] fmask(input int a);
    logic [DATA_W-1:0] m;
    m = '0;
    case (a)
      A_HTOT, A_VTOT, A_WIN_TL, A_WIN_BR: begin
        m[CW-1:0]              = '1;
        m[HI_LSB+CW-1:HI_LSB]  = '1;
      end
      A_HSYNC, A_VSYNC: begin
        m[CW-1:0]              = '1;
        m[HI_LSB+SW-1:HI_LSB]  = '1;
      end
      A_CTRL:  m[CTRL_W-1:0] = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  logic [DATA_W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              we;
    logic [DATA_W-1:0] d;
    always_comb begin
      we = wr_en && (wr_addr == ADDR_W'(i));
      d  = wr_data & fmask(i);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= '0;
      else if (we) q[i] <= d;
    end
  end

  always_comb begin
    rd_data = q[rd_addr];
    hde   = q[A_HTOT][CW-1:0];
    htot  = q[A_HTOT][HI_LSB+CW-1:HI_LSB];
    hss   = q[A_HSYNC][CW-1:0];
    hsw   = q[A_HSYNC][HI_LSB+SW-1:HI_LSB];
    vde   = q[A_VTOT][CW-1:0];
    vtot  = q[A_VTOT][HI_LSB+CW-1:HI_LSB];
    vss   = q[A_VSYNC][CW-1:0];
    vsw   = q[A_VSYNC][HI_LSB+SW-1:HI_LSB];
    win_l = q[A_WIN_TL][CW-1:0];
    win_t = q[A_WIN_TL][HI_LSB+CW-1:HI_LSB];
    win_r = q[A_WIN_BR][CW-1:0];
    win_b = q[A_WIN_BR][HI_LSB+CW-1:HI_LSB];
    ctrl  = q[A_CTRL][CTRL_W-1:0];
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt
);
  logic          hwrap;
  logic          vwrap;
  logic [CW-1:0] hcnt_d;
  logic [CW-1:0] vcnt_d;

  always_comb begin
    hwrap  = hcnt >= htot;
    vwrap  = vcnt >= vtot;
    hcnt_d = hcnt;
    vcnt_d = vcnt;
    if (!run) begin
      hcnt_d = '0;
      vcnt_d = '0;
    end else if (hwrap) begin
      hcnt_d = '0;
      vcnt_d = vwrap ? '0 : vcnt + 1'b1;
    end else begin
      hcnt_d = hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hcnt_d;
      vcnt <= vcnt_d;
    end
  end
endmodule

// File: rtl/rtg_span.sv
module rtg_span #(
  parameter int CW = 12,
  parameter int SW = 8
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [SW-1:0] len,
  output logic          on
);
  logic [CW-1:0] off;
  always_comb begin
    off = cnt - start;
    on  = (cnt >= start) && (off < {{(CW-SW){1'b0}}, len});
  end
endmodule

// File: rtl/rtg_outputs.sv
module rtg_outputs #(
  parameter int CW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          plane_req,
  input  logic          hpol,
  input  logic          vpol,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic [CW-1:0] hde,
  input  logic [CW-1:0] vde,
  input  logic [CW-1:0] hss,
  input  logic [SW-1:0] hsw,
  input  logic [CW-1:0] vss,
  input  logic [SW-1:0] vsw,
  input  logic [CW-1:0] win_l,
  input  logic [CW-1:0] win_t,
  input  logic [CW-1:0] win_r,
  input  logic [CW-1:0] win_b,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          vis,
  output logic          plane_on,
  output logic          vs_rise
);
  localparam int NAX = 2;

  logic [CW-1:0] ax_cnt   [NAX];
  logic [CW-1:0] ax_start [NAX];
  logic [SW-1:0] ax_len   [NAX];
  logic [NAX-1:0] ax_on;

  always_comb begin
    ax_cnt[0] = hcnt; ax_start[0] = hss; ax_len[0] = hsw;
    ax_cnt[1] = vcnt; ax_start[1] = vss; ax_len[1] = vsw;
  end

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    rtg_span #(.CW(CW), .SW(SW)) u_span (
      .cnt   (ax_cnt[a]),
      .start (ax_start[a]),
      .len   (ax_len[a]),
      .on    (ax_on[a])
    );
  end

  logic vs_q, vs_d;
  logic plane_d;
  logic in_vis, in_win;

  always_comb begin
    vs_d    = run & ax_on[1];
    vs_rise = vs_d & ~vs_q;
    plane_d = vs_rise ? plane_req : plane_on;
    in_vis  = (hcnt <= hde) && (vcnt <= vde);
    in_win  = (hcnt >= win_l) && (hcnt <= win_r) &&
              (vcnt >= win_t) && (vcnt <= win_b);
    de      = run & in_vis & in_win;
    vis     = de & plane_on;
    hsync   = hpol ^ (run & ax_on[0]);
    vsync   = vpol ^ vs_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q     <= 1'b0;
      plane_on <= 1'b0;
    end else begin
      vs_q     <= vs_d;
      plane_on <= plane_d;
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              vis,
  output logic [CW-1:0]     x,
  output logic [CW-1:0]     y,
  output logic [CLK_W-1:0]  clk_sel,
  output logic              plane_on
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [CW-1:0]     htot, hde, hss, vtot, vde, vss;
  logic [CW-1:0]     win_l, win_t, win_r, win_b;
  logic [SW-1:0]     hsw, vsw;
  logic [CTRL_W-1:0] ctrl;
  logic              run, vs_rise;

  rtg_regs #(.CW(CW), .SW(SW)) u_regs (
    .clk (clk), .rst_n (rst_sync_n),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data),
    .htot (htot), .hde (hde), .hss (hss), .hsw (hsw),
    .vtot (vtot), .vde (vde), .vss (vss), .vsw (vsw),
    .win_l (win_l), .win_t (win_t), .win_r (win_r), .win_b (win_b),
    .ctrl (ctrl)
  );

  assign run     = ctrl[C_RUN];
  assign clk_sel = ctrl[C_CLK_LO+CLK_W-1:C_CLK_LO];

  rtg_counters #(.CW(CW)) u_cnt (
    .clk (clk), .rst_n (rst_sync_n), .run (run),
    .htot (htot), .vtot (vtot), .hcnt (x), .vcnt (y)
  );

  rtg_outputs #(.CW(CW), .SW(SW)) u_out (
    .clk (clk), .rst_n (rst_sync_n), .run (run),
    .plane_req (ctrl[C_PLANE]), .hpol (ctrl[C_HPOL]), .vpol (ctrl[C_VPOL]),
    .hcnt (x), .vcnt (y), .hde (hde), .vde (vde),
    .hss (hss), .hsw (hsw), .vss (vss), .vsw (vsw),
    .win_l (win_l), .win_t (win_t), .win_r (win_r), .win_b (win_b),
    .hsync (hsync), .vsync (vsync), .de (de), .vis (vis),
    .plane_on (plane_on), .vs_rise (vs_rise)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int CW = 12,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          hpol,
  input logic          vpol,
  input logic [CW-1:0] x,
  input logic [CW-1:0] y,
  input logic [CW-1:0] htot,
  input logic [SW-1:0] hsw,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          vis,
  input logic          plane_on,
  input logic          vs_rise
);
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && ($past(x) < $past(htot)) && (htot == $past(htot)))
      |-> (x == $past(x) + 1'b1)); // R3

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (x != '0)) |-> (y == $past(y))); // R4

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!de && (hsync == hpol) && (vsync == vpol))); // R9

  AST_HS_ZERO_W: assert property (@(posedge clk) disable iff (!rst_n)
    (hsw == '0) |-> (hsync == hpol)); // R6

  AST_PLANE_AT_VS: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_on != $past(plane_on)) |-> $past(vs_rise)); // R10

  AST_VIS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    vis |-> (de && plane_on)); // R10
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW), .SW(SW)) u_chk (
  .clk (clk), .rst_n (rst_sync_n), .run (run),
  .hpol (ctrl[rtg_pkg::C_HPOL]), .vpol (ctrl[rtg_pkg::C_VPOL]),
  .x (x), .y (y), .htot (htot), .hsw (hsw),
  .hsync (hsync), .vsync (vsync), .de (de), .vis (vis),
  .plane_on (plane_on), .vs_rise (vs_rise)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        hsync, vsync, de, vis, plane_on;
  logic [11:0] x, y;
  logic [2:0]  clk_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int HT = 9, HD = 5, HS = 7, HW = 2;
  int VT = 5, VD = 3, VS = 4, VW = 1;
  int WL = 0, WT = 0, WR = 5, WB = 3;

  always #5 clk = ~clk;

  raster_timing_gen dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .hsync (hsync), .vsync (vsync), .de (de), .vis (vis),
    .x (x), .y (y), .clk_sel (clk_sel), .plane_on (plane_on)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pk(input int hi, input int lo);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  function automatic logic [31:0] cw(input bit run, input bit pl, input bit hp,
                                     input bit vp, input int ck);
    return 32'(run) | (32'(pl) << 1) | (32'(hp) << 2) | (32'(vp) << 3) | (32'(ck) << 4);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_mode();
    wr(0, pk(HT, HD));
    wr(1, pk(HW, HS));
    wr(2, pk(VT, VD));
    wr(3, pk(VW, VS));
    wr(5, pk(WT, WL));
    wr(6, pk(WB, WR));
  endtask

  // restart counting from zero and follow a cycle-accurate model
  task automatic t_scan(input bit hp, input bit vp, input int n);
    int ex, ey;
    bit eh, ev, ed;
    wr(4, cw(0, 0, hp, vp, 0));
    @(negedge clk);
    wr(4, cw(1, 0, hp, vp, 0));
    ex = 0; ey = 0;
    for (int i = 0; i < n; i++) begin
      eh = hp ^ ((ex >= HS) && (ex < HS + HW));
      ev = vp ^ ((ey >= VS) && (ey < VS + VW));
      ed = (ex <= HD) && (ey <= VD) && (ex >= WL) && (ex <= WR) && (ey >= WT) && (ey <= WB);
      chk(x == 12'(ex), "R3 x", x, ex);
      chk(y == 12'(ey), "R4 y", y, ey);
      chk(de == ed, "R5/R12 de", de, ed);
      chk(hsync == eh, "R6/R8 hsync", hsync, eh);
      chk(vsync == ev, "R7/R8 vsync", vsync, ev);
      @(negedge clk);
      if (ex == HT) begin
        ex = 0;
        ey = (ey == VT) ? 0 : ey + 1;
      end else ex++;
    end
  endtask

  task automatic t_reset();
    rd_addr = 3'd4;
    chk(x == 0 && y == 0, "R1 counters", {x, y}, 0);
    chk(!de && !vis && !plane_on, "R1 de/vis/plane", {de, vis, plane_on}, 0);
    chk(!hsync && !vsync, "R1 syncs", {hsync, vsync}, 0);
    chk(clk_sel == 0, "R1 clk_sel", clk_sel, 0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk(rd_data == 0, "R1 readback", rd_data, 0);
    end
  endtask

  task automatic t_regs();
    wr(0, 32'hFFFF_FFFF);
    rd_addr = 3'd0; #1;
    chk(rd_data == 32'h0FFF_0FFF, "R2 line setup mask", rd_data, 32'h0FFF_0FFF);
    wr(1, 32'hFFFF_FFFF);
    rd_addr = 3'd1; #1;
    chk(rd_data == 32'h00FF_0FFF, "R2 line sync mask", rd_data, 32'h00FF_0FFF);
    wr(4, 32'hFFFF_FF00 | 32'h50);
    rd_addr = 3'd4; #1;
    chk(rd_data == 32'h50, "R2 ctrl mask", rd_data, 32'h50);
    chk(clk_sel == 3'd5, "R11 clk_sel", clk_sel, 5);
    wr(7, 32'h1234_5678);
    rd_addr = 3'd7; #1;
    chk(rd_data == 0, "R2 unmapped", rd_data, 0);
    wr(4, cw(0, 0, 0, 0, 3));
    chk(clk_sel == 3'd3, "R11 clk_sel update", clk_sel, 3);
    program_mode();
    rd_addr = 3'd3; #1;
    chk(rd_data == pk(VW, VS), "R2 frame sync", rd_data, pk(VW, VS));
  endtask

  task automatic t_idle();
    wr(4, cw(1, 0, 0, 0, 0));
    repeat (7) @(negedge clk);
    wr(4, cw(0, 0, 1, 1, 0));
    @(negedge clk);
    chk(x == 0 && y == 0, "R9 counters cleared", {x, y}, 0);
    chk(hsync && vsync, "R9/R8 idle level", {hsync, vsync}, 3);
    chk(!de, "R9 de low", de, 0);
    repeat (5) @(negedge clk);
    chk(x == 0, "R9 counters held", x, 0);
  endtask

  task automatic t_plane();
    int guard;
    wr(4, cw(1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    wr(4, cw(1, 1, 0, 0, 0));
    rd_addr = 3'd4; #1;
    chk(rd_data[1] == 1'b1, "R2/R10 pending readback", rd_data[1], 1);
    chk(plane_on == 1'b0, "R10 not yet applied", plane_on, 0);
    guard = 0;
    while (vsync && guard < 500) begin @(negedge clk); guard++; end
    while (!vsync && guard < 500) begin
      chk(plane_on == 1'b0, "R10 held before vsync", plane_on, 0);
      @(negedge clk); guard++;
    end
    chk(plane_on == 1'b0, "R10 first vsync cycle", plane_on, 0);
    @(negedge clk);
    chk(plane_on == 1'b1, "R10 applied after vsync", plane_on, 1);
    for (int i = 0; i < 70; i++) begin
      chk(vis == de, "R10 vis gate", vis, de);
      @(negedge clk);
    end
    wr(4, cw(1, 0, 0, 0, 0));
    chk(plane_on == 1'b1, "R10 clear deferred", plane_on, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_scan(0, 0, 130);
    t_idle();
    t_scan(1, 1, 70);
    WL = 1; WR = 3; WT = 1; WB = 2;
    program_mode();
    t_scan(0, 0, 70);
    HW = 0;
    program_mode();
    t_scan(0, 1, 70);
    HW = 2;
    program_mode();
    t_plane();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule